// File: doc/BRIEF.md
# DMA Descriptor Completion Status Reporter

This block tells the host when selected DMA descriptors have finished. It serves two channels, one for read descriptors and one for write descriptors. Each channel has its own status table in host memory. The table holds one 32-bit word per descriptor ID and starts at a base address that the host programs. The host asks for a report by writing a descriptor ID to that channel's report-request input. It may request several IDs in turn, for example 63 and then 127. Each requested ID gets exactly one report.

Completion events arrive tagged with a descriptor ID, in any order. A completion for an ID that has a pending request is queued. The block then issues a memory write of the done word to `base + 4*ID`. Once that write is accepted, it raises a one-cycle MSI request that is tagged with the channel. Completions for IDs that were never requested are dropped silently. A single memory-write port is shared by both channels under round-robin arbitration.

Top module: `dma_cpl_status_reporter`

## Requirements
- R1: After reset, `mw_valid` and `msi_req` are 0, and no report request is pending on either channel.
- R2: The status address is the channel base with its low 5 bits forced to zero, plus 4 times the descriptor ID. Whatever the host writes into base bits [4:0] has no effect.
- R3: The two channels use separate tables and separate request sets. A read completion uses the read base. A request on one channel does not make a completion of the same ID on the other channel reportable.
- R4: A completion whose ID has no pending request on its channel produces no memory write and no MSI.
- R5: Every ID the host requests produces its own status write when that descriptor completes. The request is consumed when the write is accepted, so a later completion of the same ID is not reported unless the ID is requested again.
- R6: Completions may arrive in any ID order. Reports for one channel are issued in the order their completions arrived.
- R7: The status data word is 0x00000001: bit 0 is the done flag and all other bits are zero.
- R8: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold their values.
- R9: In the cycle after a write is accepted, `msi_req` pulses high for exactly one cycle. `msi_chan` is 0 for the read channel and 1 for the write channel.
- R10: When both channels have queued reports, grants alternate between the channels.
- R11: A report request and a completion for the same ID on the same channel in the same cycle count as a requested completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_base_we | input | 1 | Load the read-channel table base |
| rd_base | input | ADDR_W | Read-channel table base address |
| wr_base_we | input | 1 | Load the write-channel table base |
| wr_base | input | ADDR_W | Write-channel table base address |
| rd_req_we | input | 1 | Read-channel report request strobe |
| rd_req_id | input | ID_W | Descriptor ID to report on the read channel |
| wr_req_we | input | 1 | Write-channel report request strobe |
| wr_req_id | input | ID_W | Descriptor ID to report on the write channel |
| rd_cpl_valid | input | 1 | Read descriptor completion event |
| rd_cpl_id | input | ID_W | ID of the completed read descriptor |
| wr_cpl_valid | input | 1 | Write descriptor completion event |
| wr_cpl_id | input | ID_W | ID of the completed write descriptor |
| mw_valid | output | 1 | Status memory-write request valid |
| mw_addr | output | ADDR_W | Status word byte address |
| mw_data | output | 32 | Status word |
| mw_ready | input | 1 | Memory-write request accepted |
| msi_req | output | 1 | One-cycle MSI request |
| msi_chan | output | 1 | Channel of the MSI: 0 read, 1 write |

## Verification
The hardest situation to reach is contention for the shared port. It needs both channels to hold queued reports at once, while the port is still busy, so that the round-robin pointer decides. The stimulus requests one ID on each channel, completes both in the same cycle, and completes a second pair one cycle later. The expected order then comes from the channel that was granted last in the preceding scenario. Out-of-order arrival is covered by completing 127 before 63. Request consumption is covered by completing 63 a second time.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic {
    CH_RD = 1'b0,
    CH_WR = 1'b1
  } dcs_chan_e;

  localparam int unsigned NUM_CH = 2;
  localparam logic [31:0] DONE_WORD = 32'h0000_0001;
  localparam int unsigned BASE_ALIGN_BITS = 5;
endpackage

// File: rtl/dcs_fifo.sv
module dcs_fifo #(
  parameter int unsigned W     = 7,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (PW+1)'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/dcs_channel.sv
module dcs_channel #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned NUM_DESC   = 128,
  parameter int unsigned ID_W       = 7,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              req_we,
  input  logic [ID_W-1:0]   req_id,
  input  logic              cpl_valid,
  input  logic [ID_W-1:0]   cpl_id,
  input  logic              clr_valid,
  input  logic [ID_W-1:0]   clr_id,
  input  logic              pop,
  output logic              pend,
  output logic [ID_W-1:0]   head_id,
  output logic [ADDR_W-1:0] head_addr
);
  import dcs_pkg::*;

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BASE_ALIGN_BITS) - 1);

  logic [ADDR_W-1:0]   base_q;
  logic [NUM_DESC-1:0] want_q;
  logic                hit, push, empty, full;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_we) base_q <= base_in & ALIGN_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q <= '0;
    end else begin
      if (clr_valid) want_q[clr_id] <= 1'b0;
      if (req_we)    want_q[req_id] <= 1'b1;
    end
  end

  assign hit  = want_q[cpl_id] || (req_we && (req_id == cpl_id));
  assign push = cpl_valid && hit;

  dcs_fifo #(.W(ID_W), .DEPTH(FIFO_DEPTH)) u_q (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (cpl_id),
    .pop       (pop),
    .head      (head_id),
    .empty     (empty),
    .full      (full)
  );

  assign pend      = !empty;
  assign head_addr = base_q + ADDR_W'({head_id, 2'b00});

  // R5
  clear_requested_chk: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> want_q[clr_id]);

  // R2
  base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    base_q[BASE_ALIGN_BITS-1:0] == '0);

  // R6
  fifo_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
endmodule

// File: rtl/dcs_arb.sv
module dcs_arb #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ID_W   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          pend,
  input  logic [1:0][ID_W-1:0]   id_in,
  input  logic [1:0][ADDR_W-1:0] addr_in,
  output logic [1:0]          pop,
  output logic [1:0]          clr_valid,
  output logic [ID_W-1:0]     clr_id,
  output logic                mw_valid,
  output logic [ADDR_W-1:0]   mw_addr,
  output logic [31:0]         mw_data,
  input  logic                mw_ready,
  output logic                msi_req,
  output logic                msi_chan
);
  import dcs_pkg::*;

  dcs_chan_e        last_q, gnt, cur_q;
  logic [ID_W-1:0]  cur_id_q;
  logic             load, accept;

  always_comb begin
    if (pend[0] && pend[1]) gnt = (last_q == CH_RD) ? CH_WR : CH_RD;
    else if (pend[1])       gnt = CH_WR;
    else                    gnt = CH_RD;
  end

  assign load   = !mw_valid && (pend != 2'b00);
  assign accept = mw_valid && mw_ready;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_side
      assign pop[c]       = load && (gnt == dcs_chan_e'(c));
      assign clr_valid[c] = accept && (cur_q == dcs_chan_e'(c));
    end
  endgenerate

  assign clr_id = cur_id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
      cur_q    <= CH_RD;
      cur_id_q <= '0;
      last_q   <= CH_WR;
      msi_req  <= 1'b0;
      msi_chan <= 1'b0;
    end else begin
      msi_req <= accept;
      if (accept) begin
        mw_valid <= 1'b0;
        msi_chan <= cur_q;
      end else if (load) begin
        mw_valid <= 1'b1;
        mw_addr  <= addr_in[gnt];
        mw_data  <= DONE_WORD;
        cur_q    <= gnt;
        cur_id_q <= id_in[gnt];
        last_q   <= gnt;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R9
  msi_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && mw_ready) |=> msi_req);

  // R9
  msi_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    msi_req |=> !msi_req);

  // R2
  addr_word_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> (mw_addr[1:0] == 2'b00));

  // R10
  rr_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (load && pend[0] && pend[1]) |-> (gnt != last_q));

  // R6
  one_pop_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop));
endmodule

// File: rtl/dma_cpl_status_reporter.sv
module dma_cpl_status_reporter #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned NUM_DESC   = 128,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ID_W       = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_base_we,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic              wr_base_we,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              rd_req_we,
  input  logic [ID_W-1:0]   rd_req_id,
  input  logic              wr_req_we,
  input  logic [ID_W-1:0]   wr_req_id,
  input  logic              rd_cpl_valid,
  input  logic [ID_W-1:0]   rd_cpl_id,
  input  logic              wr_cpl_valid,
  input  logic [ID_W-1:0]   wr_cpl_id,
  output logic              mw_valid,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [31:0]       mw_data,
  input  logic              mw_ready,
  output logic              msi_req,
  output logic              msi_chan
);
  logic [1:0]             base_we_a, req_we_a, cpl_v_a, pend_a, pop_a, clr_v_a;
  logic [1:0][ADDR_W-1:0] base_a, addr_a;
  logic [1:0][ID_W-1:0]   req_id_a, cpl_id_a, id_a;
  logic [ID_W-1:0]        clr_id;

  assign base_we_a = {wr_base_we, rd_base_we};
  assign base_a    = {wr_base, rd_base};
  assign req_we_a  = {wr_req_we, rd_req_we};
  assign req_id_a  = {wr_req_id, rd_req_id};
  assign cpl_v_a   = {wr_cpl_valid, rd_cpl_valid};
  assign cpl_id_a  = {wr_cpl_id, rd_cpl_id};

  generate
    for (genvar c = 0; c < 2; c++) begin : g_ch
      dcs_channel #(
        .ADDR_W(ADDR_W), .NUM_DESC(NUM_DESC), .ID_W(ID_W), .FIFO_DEPTH(FIFO_DEPTH)
      ) u_ch (
        .clk       (clk),
        .rst       (rst),
        .base_we   (base_we_a[c]),
        .base_in   (base_a[c]),
        .req_we    (req_we_a[c]),
        .req_id    (req_id_a[c]),
        .cpl_valid (cpl_v_a[c]),
        .cpl_id    (cpl_id_a[c]),
        .clr_valid (clr_v_a[c]),
        .clr_id    (clr_id),
        .pop       (pop_a[c]),
        .pend      (pend_a[c]),
        .head_id   (id_a[c]),
        .head_addr (addr_a[c])
      );
    end
  endgenerate

  dcs_arb #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend_a),
    .id_in     (id_a),
    .addr_in   (addr_a),
    .pop       (pop_a),
    .clr_valid (clr_v_a),
    .clr_id    (clr_id),
    .mw_valid  (mw_valid),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data),
    .mw_ready  (mw_ready),
    .msi_req   (msi_req),
    .msi_chan  (msi_chan)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!mw_valid && !msi_req));
endmodule

// File: tb/sim_dma_cpl_status_reporter.sv
module sim_dma_cpl_status_reporter;
  localparam int AW = 64;
  localparam int IW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_base_we = 0, wr_base_we = 0, rd_req_we = 0, wr_req_we = 0;
  logic rd_cpl_valid = 0, wr_cpl_valid = 0, mw_ready = 0;
  logic [AW-1:0] rd_base = '0, wr_base = '0;
  logic [IW-1:0] rd_req_id = '0, wr_req_id = '0, rd_cpl_id = '0, wr_cpl_id = '0;
  logic mw_valid, msi_req, msi_chan;
  logic [AW-1:0] mw_addr;
  logic [31:0] mw_data;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [AW-1:0] RD_EFF = 64'h0000_0001_1000_0000;
  localparam logic [AW-1:0] WR_EFF = 64'h0000_0002_2000_0040;

  always #2.5 clk = ~clk;

  dma_cpl_status_reporter u0 (
    .clk(clk), .rst(rst),
    .rd_base_we(rd_base_we), .rd_base(rd_base),
    .wr_base_we(wr_base_we), .wr_base(wr_base),
    .rd_req_we(rd_req_we), .rd_req_id(rd_req_id),
    .wr_req_we(wr_req_we), .wr_req_id(wr_req_id),
    .rd_cpl_valid(rd_cpl_valid), .rd_cpl_id(rd_cpl_id),
    .wr_cpl_valid(wr_cpl_valid), .wr_cpl_id(wr_cpl_id),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready),
    .msi_req(msi_req), .msi_chan(msi_chan)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic request(input bit ch, input logic [IW-1:0] id);
    if (ch) begin wr_req_we = 1; wr_req_id = id; end
    else    begin rd_req_we = 1; rd_req_id = id; end
    @(negedge clk);
    rd_req_we = 0; wr_req_we = 0;
  endtask

  task automatic complete(input bit ch, input logic [IW-1:0] id);
    if (ch) begin wr_cpl_valid = 1; wr_cpl_id = id; end
    else    begin rd_cpl_valid = 1; rd_cpl_id = id; end
    @(negedge clk);
    rd_cpl_valid = 0; wr_cpl_valid = 0;
  endtask

  // waits for a write, checks it, optionally stalls, accepts it, checks the MSI
  task automatic take(input logic [AW-1:0] ea, input bit ec, input int stall, input string tag);
    int n = 0;
    logic [AW-1:0] a0;
    while (!mw_valid && n < 30) begin @(negedge clk); n++; end
    check(mw_valid === 1'b1, {tag, " write issued"}, 64'(mw_valid), 64'd1);
    if (mw_valid !== 1'b1) return;
    check(mw_addr === ea, {tag, " R2/R3 address"}, mw_addr, ea);
    check(mw_data === 32'h1, {tag, " R7 done word"}, 64'(mw_data), 64'd1);
    a0 = mw_addr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(mw_valid === 1'b1 && mw_addr === a0 && mw_data === 32'h1,
            {tag, " R8 hold while stalled"}, mw_addr, a0);
    end
    mw_ready = 1;
    @(negedge clk);
    mw_ready = 0;
    check(msi_req === 1'b1, {tag, " R9 msi after accept"}, 64'(msi_req), 64'd1);
    check(msi_chan === ec, {tag, " R9 msi channel"}, 64'(msi_chan), 64'(ec));
    @(negedge clk);
    check(msi_req === 1'b0, {tag, " R9 msi one cycle"}, 64'(msi_req), 64'd0);
  endtask

  task automatic expect_idle(input int cycles, input string tag);
    bit quiet = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (mw_valid !== 1'b0 || msi_req !== 1'b0) quiet = 0;
    end
    check(quiet, tag, 64'(mw_valid), 64'd0);
  endtask

  task automatic t_reset;
    check(mw_valid === 1'b0, "R1 mw_valid after reset", 64'(mw_valid), 64'd0);
    check(msi_req === 1'b0, "R1 msi_req after reset", 64'(msi_req), 64'd0);
    complete(1'b0, 7'd0);
    expect_idle(6, "R1 no request pending after reset");
  endtask

  task automatic t_config;
    rd_base_we = 1; rd_base = 64'h0000_0001_1000_0013;
    wr_base_we = 1; wr_base = 64'h0000_0002_2000_0047;
    @(negedge clk);
    rd_base_we = 0; wr_base_we = 0;
  endtask

  task automatic t_unrequested;
    complete(1'b0, 7'd5);
    expect_idle(6, "R4 unrequested read completion ignored");
    request(1'b0, 7'd9);
    complete(1'b1, 7'd9);
    expect_idle(6, "R3 read request does not enable write channel");
    complete(1'b0, 7'd9);
    take(RD_EFF + 64'd36, 1'b0, 0, "R3 read id 9 on read table");
  endtask

  task automatic t_multi;
    request(1'b0, 7'd63);
    request(1'b0, 7'd127);
    complete(1'b0, 7'd127);
    complete(1'b0, 7'd63);
    take(RD_EFF + 64'h1FC, 1'b0, 0, "R6 R5 id 127 first");
    take(RD_EFF + 64'hFC, 1'b0, 0, "R6 R5 id 63 second");
    complete(1'b0, 7'd63);
    expect_idle(6, "R5 request consumed, repeat completion ignored");
  endtask

  task automatic t_stall;
    request(1'b1, 7'd3);
    complete(1'b1, 7'd3);
    take(WR_EFF + 64'd12, 1'b1, 4, "R8 stalled write id 3");
  endtask

  task automatic t_rr;
    request(1'b0, 7'd10);
    request(1'b1, 7'd20);
    request(1'b0, 7'd11);
    request(1'b1, 7'd21);
    rd_cpl_valid = 1; rd_cpl_id = 7'd10;
    wr_cpl_valid = 1; wr_cpl_id = 7'd20;
    @(negedge clk);
    rd_cpl_id = 7'd11; wr_cpl_id = 7'd21;
    @(negedge clk);
    rd_cpl_valid = 0; wr_cpl_valid = 0;
    take(RD_EFF + 64'd40, 1'b0, 1, "R10 rr read 10");
    take(WR_EFF + 64'd80, 1'b1, 0, "R10 rr write 20");
    take(RD_EFF + 64'd44, 1'b0, 0, "R10 rr read 11");
    take(WR_EFF + 64'd84, 1'b1, 0, "R10 rr write 21");
  endtask

  task automatic t_same_cycle;
    wr_req_we = 1; wr_req_id = 7'd50;
    wr_cpl_valid = 1; wr_cpl_id = 7'd50;
    @(negedge clk);
    wr_req_we = 0; wr_cpl_valid = 0;
    take(WR_EFF + 64'd200, 1'b1, 0, "R11 same-cycle request and completion");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_config();
    t_unrequested();
    t_multi();
    t_stall();
    t_rr();
    t_same_cycle();
    expect_idle(4, "R4 R5 nothing left over");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule